// File: doc/BRIEF.md
# Single-Bus Register Datapath

This block is the register and arithmetic half of a small processor. All of its internal registers share one internal bus. It holds eight general-purpose registers, a program counter, an instruction register, an operand staging register X, a result staging register Y, a memory address register and a memory data register. Each cycle, an external sequencer drives a set of strobes: which register places its value on the bus, which registers capture the bus, what the ALU computes and whether memory is touched. The block carries out those strobes at the next rising clock edge.

The ALU takes the bus as one operand. The other operand comes from a two-way selector that picks either register X or the constant four. The constant lets the sequencer advance the program counter with no extra register. The ALU result can only be stored in Y. A later cycle moves it to its destination over the bus.

Memory is reached only through the address and data registers. The address register is loaded from the internal bus and drives the external address lines. The data register is loaded from the internal bus or from the external read data. It feeds both the internal bus and the external write data.

Top module: `sbus_datapath`

## Requirements
- R1: After a synchronous active-high reset, every register in the block holds zero. The bus reads zero, and `bus_conflict`, `mem_rd` and `mem_wr` are low.
- R2: When exactly one out-enable is high among `gpr_oe[k]`, `pc_oe`, `y_oe` and `mdr_oe`, `bus_out` equals that register's current value in the same cycle.
- R3: When no out-enable is high, `bus_out` is zero.
- R4: When two or more out-enables are high, `bus_conflict` is high and `bus_out` is zero. Registers that load from the bus in that cycle capture zero. With at most one out-enable high, `bus_conflict` is low.
- R5: When `y_ie` is high, Y captures `A op bus` at the edge. A is the constant 4 when `sel_four` is 1, and register X otherwise. The `alu_op` encoding is 0 for add, 1 for subtract (A minus bus), 2 for bitwise AND and 3 for bitwise OR. Results wrap modulo 2^32.
- R6: Every register whose in-enable is high captures the same bus value at one clock edge. Registers whose in-enable is low keep their value.
- R7: The address register loads only from the bus (`mar_ie`) and drives `mem_addr`. `mem_rd` follows `mem_rd_req` in the same cycle.
- R8: The data register loads `mem_rdata` when `mdr_ext_ie` is high, and otherwise loads the bus when `mdr_ie` is high. If both strobes are high, the external data wins. The register's value always drives `mem_wdata`, and `mem_wr` follows `mem_wr_req` in the same cycle.
- R9: The instruction register loads from the bus when `ir_ie` is high, and its value appears on `ir_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gpr_oe | input | 8 | Per-register bus out-enable for the general registers |
| gpr_ie | input | 8 | Per-register bus in-enable for the general registers |
| pc_oe | input | 1 | Program counter drives the bus |
| pc_ie | input | 1 | Program counter loads from the bus |
| y_oe | input | 1 | Result register Y drives the bus |
| y_ie | input | 1 | Y captures the ALU result |
| mdr_oe | input | 1 | Data register drives the internal bus |
| mdr_ie | input | 1 | Data register loads from the internal bus |
| mdr_ext_ie | input | 1 | Data register loads from external read data |
| x_ie | input | 1 | Operand register X loads from the bus |
| ir_ie | input | 1 | Instruction register loads from the bus |
| mar_ie | input | 1 | Address register loads from the bus |
| sel_four | input | 1 | ALU first operand: 1 selects constant 4, 0 selects X |
| alu_op | input | 2 | ALU operation code |
| mem_rd_req | input | 1 | Request an external read |
| mem_wr_req | input | 1 | Request an external write |
| mem_rdata | input | 32 | External read data |
| mem_addr | output | 32 | External address (address register value) |
| mem_wdata | output | 32 | External write data (data register value) |
| mem_rd | output | 1 | External read strobe |
| mem_wr | output | 1 | External write strobe |
| ir_out | output | 32 | Instruction register value |
| bus_out | output | 32 | Current internal bus value |
| bus_conflict | output | 1 | More than one bus driver this cycle |

## Verification
`bus_out`, `bus_conflict`, `mem_rd` and `mem_wr` are combinational, so they are due in the same cycle as the strobes that cause them. The bench drives strobes just after a falling edge and samples these outputs one nanosecond later, before the next rising edge. Every register load, including Y's ALU capture, appears one rising edge later. Register contents are then seen either directly on `mem_addr`, `mem_wdata` and `ir_out`, or on the bus in a later cycle that enables that register's out-enable. The bench model updates its copy of the registers at the same edge, so each comparison in cycle n uses the state left by cycle n-1.

// File: rtl/sbus_pkg.sv
`timescale 1ns/1ps
package sbus_pkg;

    parameter int unsigned WORD_W   = 32;
    parameter int unsigned GPR_N    = 8;
    parameter int unsigned STEP_VAL = 4;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_AND = 2'd2,
        OP_OR  = 2'd3
    } alu_op_e;

    typedef enum logic {
        OPA_X    = 1'b0,
        OPA_FOUR = 1'b1
    } opa_sel_e;

    // special-purpose bus sources placed after the general registers
    typedef struct packed {
        logic pc;
        logic y;
        logic mdr;
    } spr_oe_t;

    localparam int unsigned SPR_N = 3;

    function automatic int unsigned src_count(input int unsigned n_gpr);
        return n_gpr + SPR_N;
    endfunction

endpackage

// File: rtl/sbus_gpr_file.sv
`timescale 1ns/1ps
module sbus_gpr_file #(
    parameter int unsigned DW   = 32,
    parameter int unsigned NREG = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DW-1:0]        bus,
    input  logic [NREG-1:0]      ld_en,
    output logic [NREG*DW-1:0]   q_flat
);
    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (ld_en[g])
                regs[g] <= bus;
        end
        assign q_flat[g*DW +: DW] = regs[g];
    end
endmodule

// File: rtl/sbus_bus_mux.sv
`timescale 1ns/1ps
module sbus_bus_mux #(
    parameter int unsigned DW   = 32,
    parameter int unsigned NSRC = 11
) (
    input  logic [NSRC*DW-1:0] src_val,
    input  logic [NSRC-1:0]    src_oe,
    output logic [DW-1:0]      bus,
    output logic               conflict
);
    localparam int unsigned CW = $clog2(NSRC + 1);

    logic [CW-1:0] n_drv;
    logic [DW-1:0] merged;

    always_comb begin
        n_drv  = '0;
        merged = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (src_oe[i]) begin
                n_drv  = n_drv + CW'(1);
                merged = merged | src_val[i*DW +: DW];
            end
        end
    end

    assign conflict = (n_drv > CW'(1));
    assign bus      = conflict ? '0 : merged;
endmodule

// File: rtl/sbus_alu.sv
`timescale 1ns/1ps
module sbus_alu
    import sbus_pkg::*;
#(
    parameter int unsigned DW   = 32,
    parameter int unsigned STEP = 4
) (
    input  logic [DW-1:0] x_val,
    input  logic [DW-1:0] bus,
    input  opa_sel_e      opa_sel,
    input  alu_op_e       op,
    output logic [DW-1:0] result
);
    localparam logic [DW-1:0] STEP_W = DW'(STEP);

    logic [DW-1:0] opa;

    assign opa = (opa_sel == OPA_FOUR) ? STEP_W : x_val;

    always_comb begin
        unique case (op)
            OP_ADD:  result = opa + bus;
            OP_SUB:  result = opa - bus;
            OP_AND:  result = opa & bus;
            OP_OR:   result = opa | bus;
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/sbus_mem_port.sv
`timescale 1ns/1ps
module sbus_mem_port #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] bus,
    input  logic          addr_ld,
    input  logic          data_ld_int,
    input  logic          data_ld_ext,
    input  logic [DW-1:0] ext_rdata,
    input  logic          rd_req,
    input  logic          wr_req,
    output logic [DW-1:0] addr_q,
    output logic [DW-1:0] data_q,
    output logic          ext_rd,
    output logic          ext_wr
);
    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (addr_ld)
            addr_q <= bus;
    end

    always_ff @(posedge clk) begin
        if (rst)
            data_q <= '0;
        else if (data_ld_ext)
            data_q <= ext_rdata;
        else if (data_ld_int)
            data_q <= bus;
    end

    assign ext_rd = rd_req;
    assign ext_wr = wr_req;
endmodule

// File: rtl/sbus_datapath.sv
`timescale 1ns/1ps
module sbus_datapath
    import sbus_pkg::*;
#(
    parameter int unsigned DW   = sbus_pkg::WORD_W,
    parameter int unsigned NREG = sbus_pkg::GPR_N
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NREG-1:0] gpr_oe,
    input  logic [NREG-1:0] gpr_ie,
    input  logic            pc_oe,
    input  logic            pc_ie,
    input  logic            y_oe,
    input  logic            y_ie,
    input  logic            mdr_oe,
    input  logic            mdr_ie,
    input  logic            mdr_ext_ie,
    input  logic            x_ie,
    input  logic            ir_ie,
    input  logic            mar_ie,
    input  logic            sel_four,
    input  logic [1:0]      alu_op,
    input  logic            mem_rd_req,
    input  logic            mem_wr_req,
    input  logic [DW-1:0]   mem_rdata,
    output logic [DW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [DW-1:0]   ir_out,
    output logic [DW-1:0]   bus_out,
    output logic            bus_conflict
);
    localparam int unsigned NSRC = src_count(NREG);

    logic [DW-1:0]      bus;
    logic [NREG*DW-1:0] gpr_flat;
    logic [DW-1:0]      pc_q, ir_q, x_q, y_q;
    logic [DW-1:0]      alu_res;
    logic [DW-1:0]      mdr_q;
    spr_oe_t            spr_oe;
    logic [NSRC-1:0]    src_oe;
    logic [NSRC*DW-1:0] src_val;

    assign spr_oe = '{pc: pc_oe, y: y_oe, mdr: mdr_oe};
    assign src_oe  = {spr_oe, gpr_oe};
    assign src_val = {pc_q, y_q, mdr_q, gpr_flat};

    sbus_gpr_file #(.DW(DW), .NREG(NREG)) u_gpr (
        .clk    (clk),
        .rst    (rst),
        .bus    (bus),
        .ld_en  (gpr_ie),
        .q_flat (gpr_flat)
    );

    sbus_bus_mux #(.DW(DW), .NSRC(NSRC)) u_bus (
        .src_val  (src_val),
        .src_oe   (src_oe),
        .bus      (bus),
        .conflict (bus_conflict)
    );

    sbus_alu #(.DW(DW), .STEP(STEP_VAL)) u_alu (
        .x_val   (x_q),
        .bus     (bus),
        .opa_sel (opa_sel_e'(sel_four)),
        .op      (alu_op_e'(alu_op)),
        .result  (alu_res)
    );

    sbus_mem_port #(.DW(DW)) u_mem (
        .clk         (clk),
        .rst         (rst),
        .bus         (bus),
        .addr_ld     (mar_ie),
        .data_ld_int (mdr_ie),
        .data_ld_ext (mdr_ext_ie),
        .ext_rdata   (mem_rdata),
        .rd_req      (mem_rd_req),
        .wr_req      (mem_wr_req),
        .addr_q      (mem_addr),
        .data_q      (mdr_q),
        .ext_rd      (mem_rd),
        .ext_wr      (mem_wr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            ir_q <= '0;
            x_q  <= '0;
            y_q  <= '0;
        end else begin
            if (pc_ie) pc_q <= bus;
            if (ir_ie) ir_q <= bus;
            if (x_ie)  x_q  <= bus;
            if (y_ie)  y_q  <= alu_res;
        end
    end

    assign mem_wdata = mdr_q;
    assign ir_out    = ir_q;
    assign bus_out   = bus;
endmodule

// File: rtl/sbus_checker.sv
`timescale 1ns/1ps
module sbus_checker #(
    parameter int unsigned DW   = 32,
    parameter int unsigned NREG = 8
) (
    input logic            clk,
    input logic            rst,
    input logic [NREG-1:0] gpr_oe,
    input logic            pc_oe,
    input logic            y_oe,
    input logic            mdr_oe,
    input logic            mdr_ie,
    input logic            mdr_ext_ie,
    input logic            ir_ie,
    input logic            mar_ie,
    input logic [DW-1:0]   mem_rdata,
    input logic [DW-1:0]   mem_addr,
    input logic [DW-1:0]   mem_wdata,
    input logic [DW-1:0]   ir_out,
    input logic [DW-1:0]   bus_out,
    input logic            bus_conflict
);
    logic [NREG+2:0] all_oe;
    assign all_oe = {gpr_oe, pc_oe, y_oe, mdr_oe};

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (all_oe == '0) |-> (bus_out == '0)); // R3
    AST_CONFLICT_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_conflict |-> (bus_out == '0)); // R4
    AST_SINGLE_NO_CONFLICT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(all_oe) |-> !bus_conflict); // R4
    AST_MAR_FROM_BUS: assert property (@(posedge clk) disable iff (rst)
        mar_ie |=> (mem_addr == $past(bus_out))); // R7
    AST_MAR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !mar_ie |=> $stable(mem_addr)); // R6
    AST_MDR_EXT_WINS: assert property (@(posedge clk) disable iff (rst)
        mdr_ext_ie |=> (mem_wdata == $past(mem_rdata))); // R8
    AST_MDR_FROM_BUS: assert property (@(posedge clk) disable iff (rst)
        (mdr_ie && !mdr_ext_ie) |=> (mem_wdata == $past(bus_out))); // R8
    AST_IR_FROM_BUS: assert property (@(posedge clk) disable iff (rst)
        ir_ie |=> (ir_out == $past(bus_out))); // R9
    AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ir_ie |=> $stable(ir_out)); // R6
endmodule

bind sbus_datapath sbus_checker #(.DW(DW), .NREG(NREG)) u_sbus_chk (
    .clk          (clk),
    .rst          (rst),
    .gpr_oe       (gpr_oe),
    .pc_oe        (pc_oe),
    .y_oe         (y_oe),
    .mdr_oe       (mdr_oe),
    .mdr_ie       (mdr_ie),
    .mdr_ext_ie   (mdr_ext_ie),
    .ir_ie        (ir_ie),
    .mar_ie       (mar_ie),
    .mem_rdata    (mem_rdata),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .ir_out       (ir_out),
    .bus_out      (bus_out),
    .bus_conflict (bus_conflict)
);

// File: tb/test_sbus_datapath.sv
`timescale 1ns/1ps
module test_sbus_datapath;
    localparam int NR = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NR-1:0] gpr_oe, gpr_ie;
    logic          pc_oe, pc_ie, y_oe, y_ie, mdr_oe, mdr_ie, mdr_ext_ie;
    logic          x_ie, ir_ie, mar_ie, sel_four, mem_rd_req, mem_wr_req;
    logic [1:0]    alu_op;
    logic [31:0]   mem_rdata;
    logic [31:0]   mem_addr, mem_wdata, ir_out, bus_out;
    logic          mem_rd, mem_wr, bus_conflict;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // bench model of register state
    logic [31:0] m_gpr [NR];
    logic [31:0] m_pc, m_ir, m_x, m_y, m_mar, m_mdr;

    always #5 clk = ~clk;

    sbus_datapath i_sbus_datapath (
        .clk(clk), .rst(rst), .gpr_oe(gpr_oe), .gpr_ie(gpr_ie),
        .pc_oe(pc_oe), .pc_ie(pc_ie), .y_oe(y_oe), .y_ie(y_ie),
        .mdr_oe(mdr_oe), .mdr_ie(mdr_ie), .mdr_ext_ie(mdr_ext_ie),
        .x_ie(x_ie), .ir_ie(ir_ie), .mar_ie(mar_ie), .sel_four(sel_four),
        .alu_op(alu_op), .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_out(ir_out),
        .bus_out(bus_out), .bus_conflict(bus_conflict)
    );

    function automatic logic [31:0] alu_ref(input logic [1:0] op,
                                            input logic [31:0] a,
                                            input logic [31:0] b);
        case (op)
            2'd0:    return a + b;
            2'd1:    return a - b;
            2'd2:    return a & b;
            default: return a | b;
        endcase
    endfunction

    function automatic int drivers();
        return $countones(gpr_oe) + int'(pc_oe) + int'(y_oe) + int'(mdr_oe);
    endfunction

    function automatic logic [31:0] bus_ref();
        logic [31:0] v;
        v = '0;
        if (drivers() != 1) return '0;
        for (int k = 0; k < NR; k++) if (gpr_oe[k]) v = m_gpr[k];
        if (pc_oe)  v = m_pc;
        if (y_oe)   v = m_y;
        if (mdr_oe) v = m_mdr;
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        gpr_oe = '0; gpr_ie = '0; pc_oe = 0; pc_ie = 0; y_oe = 0; y_ie = 0;
        mdr_oe = 0; mdr_ie = 0; mdr_ext_ie = 0; x_ie = 0; ir_ie = 0;
        mar_ie = 0; sel_four = 0; alu_op = 2'd0; mem_rd_req = 0; mem_wr_req = 0;
        mem_rdata = '0;
    endtask

    // inputs are set just after a falling edge; check, update model, move on
    task automatic step(input string tag);
        logic [31:0] b;
        #1;
        b = bus_ref();
        if (drivers() == 0)      chk({"R3 ", tag}, bus_out, 32'h0);
        else if (drivers() == 1) chk({"R2 ", tag}, bus_out, b);
        else                     chk({"R4 ", tag}, bus_out, 32'h0);
        chk("R4 conflict flag", {31'h0, bus_conflict}, {31'h0, drivers() > 1});
        chk("R7 mem_addr", mem_addr, m_mar);
        chk("R7 mem_rd", {31'h0, mem_rd}, {31'h0, mem_rd_req});
        chk("R8 mem_wdata", mem_wdata, m_mdr);
        chk("R8 mem_wr", {31'h0, mem_wr}, {31'h0, mem_wr_req});
        chk("R9 ir_out", ir_out, m_ir);
        if (y_ie) m_y = alu_ref(alu_op, sel_four ? 32'd4 : m_x, b); // R5
        for (int k = 0; k < NR; k++) if (gpr_ie[k]) m_gpr[k] = b;   // R6
        if (pc_ie)  m_pc  = b;
        if (x_ie)   m_x   = b;
        if (ir_ie)  m_ir  = b;
        if (mar_ie) m_mar = b;
        if (mdr_ext_ie) m_mdr = mem_rdata;
        else if (mdr_ie) m_mdr = b;
        @(negedge clk);
        clear_in();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_in();
        for (int k = 0; k < NR; k++) m_gpr[k] = '0;
        m_pc = '0; m_ir = '0; m_x = '0; m_y = '0; m_mar = '0; m_mdr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: every source reads zero after reset
        #1;
        chk("R1 bus idle", bus_out, 32'h0);
        chk("R1 conflict", {31'h0, bus_conflict}, 32'h0);
        chk("R1 rd/wr", {30'h0, mem_rd, mem_wr}, 32'h0);
        for (int k = 0; k < NR; k++) begin
            gpr_oe[k] = 1'b1; #1;
            chk("R1 gpr", bus_out, 32'h0);
            gpr_oe[k] = 1'b0;
        end
        pc_oe = 1; #1; chk("R1 pc", bus_out, 32'h0); pc_oe = 0;
        y_oe = 1;  #1; chk("R1 y", bus_out, 32'h0);  y_oe = 0;
        mdr_oe = 1; #1; chk("R1 mdr", bus_out, 32'h0); mdr_oe = 0;
        @(negedge clk);

        // R5: PC advance by four via Y, then write back
        pc_oe = 1; mar_ie = 1; sel_four = 1; alu_op = 2'd0; y_ie = 1; mem_rd_req = 1;
        step("fetch addr");
        y_oe = 1; pc_ie = 1; step("pc update");
        pc_oe = 1; step("pc read");
        chk("R5 pc plus four", m_pc, 32'd4);

        // R8: external load wins over bus load
        mem_rdata = 32'hDEAD_BEEF; mdr_ext_ie = 1; mdr_ie = 1; pc_oe = 1;
        step("mdr both");
        mdr_oe = 1; ir_ie = 1; x_ie = 1; step("mdr to ir");
        chk("R8 ext priority", m_mdr, 32'hDEAD_BEEF);

        // R5: subtract with X operand: X=DEADBEEF, bus=PC(4)
        pc_oe = 1; alu_op = 2'd1; y_ie = 1; step("sub");
        y_oe = 1; gpr_ie[3] = 1; step("y to r3");
        gpr_oe[3] = 1; step("r3 read");
        chk("R5 sub result", m_gpr[3], 32'hDEAD_BEEB);

        // R4: conflict loads zero into the destination
        gpr_oe[3] = 1; mdr_oe = 1; gpr_ie[5] = 1; step("conflict");
        gpr_oe[5] = 1; step("r5 after conflict");

        // constrained random traffic
        for (int it = 0; it < 3000; it++) begin
            int src;
            src = $urandom_range(0, NR + 3);
            if (src < NR)        gpr_oe[src] = 1'b1;
            else if (src == NR)  pc_oe  = 1'b1;
            else if (src == NR+1) y_oe  = 1'b1;
            else if (src == NR+2) mdr_oe = 1'b1;
            if ($urandom_range(0, 9) == 0) gpr_oe[$urandom_range(0, NR-1)] = 1'b1;
            for (int k = 0; k < NR; k++) gpr_ie[k] = ($urandom_range(0, 5) == 0);
            pc_ie      = ($urandom_range(0, 5) == 0);
            y_ie       = ($urandom_range(0, 2) == 0);
            x_ie       = ($urandom_range(0, 3) == 0);
            ir_ie      = ($urandom_range(0, 5) == 0);
            mar_ie     = ($urandom_range(0, 3) == 0);
            mdr_ie     = ($urandom_range(0, 4) == 0);
            mdr_ext_ie = ($urandom_range(0, 4) == 0);
            sel_four   = $urandom_range(0, 1);
            alu_op     = 2'($urandom_range(0, 3));
            mem_rd_req = $urandom_range(0, 1);
            mem_wr_req = $urandom_range(0, 1);
            mem_rdata  = $urandom;
            step("random");
        end
        finish_run();
    end
endmodule